// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Port

This block is a half-duplex synchronous serial port that clocks one byte in or out per transfer. It generates its own shift clock from the system clock and owns a single data line: it drives that line with an output enable when it sends and samples it when it receives. Software-side control arrives through a small register write port. One address holds a 16-bit divisor word, one holds the byte to send, and one takes a start command that also selects the direction.

The divisor word holds a 15-bit count N in its low bits and an internal-clock select in its top bit. Each shift clock period lasts 2*(N+1) system clocks, split evenly into a low half followed by a high half. The clock rests high between transfers. Transmit accepts N as low as 1, which gives a 4-cycle period. Receive needs N of at least 2, which gives a 6-cycle period. After a transmit, the data line is released a fixed number of system clocks after the last rising edge. A done flag marks a finished byte. An error flag marks a start command that was refused.

Top module: `sync_shift_port`

## Requirements
- R1: After reset the shift clock is high, the data output enable is low, and done, err and the received byte are all zero.
- R2: During a transfer the shift clock goes low for N+1 system clocks and then high for N+1 system clocks, which makes a period of 2*(N+1). A transfer has exactly 8 rising edges, and the clock stays high once the eighth one has occurred.
- R3: Transmit sends the byte least significant bit first. Bit 0 is on the data output from the start edge. Each later bit is launched one system clock after a rising shift-clock edge and holds until the following rising edge. The output changes only while the clock is high.
- R4: Receive samples the data input at each rising shift-clock edge. The first sampled bit becomes bit 0. The received byte output is updated on the eighth rising edge.
- R5: A transmit start with divisor word 16'h8001 (N=1) runs with a 4-cycle clock period. A transmit start with N=0 is refused.
- R6: A receive start with divisor word 16'h8002 (N=2) runs with a 6-cycle clock period. A receive start with N below 2 is refused.
- R7: A start is refused whenever bit 15 of the divisor word is 0.
- R8: A refused start sets err, causes no shift-clock activity and leaves done unchanged. An accepted start clears both err and done.
- R9: done rises on the same system clock edge as the eighth rising shift-clock edge, and not before it.
- R10: In transmit, the output enable drops exactly 5 system clocks after the eighth rising edge. In receive, the output enable is never asserted.
- R11: Register map: address 0 holds the divisor word, address 1 holds the transmit byte (bits 7:0), and address 2 is the command register. In the command register, bit 0 is start and bit 1 selects transmit (1) or receive (0). A start written while a transfer or its release delay is in progress is ignored. Writes to addresses 0 and 1 during a transfer do not change that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 divisor, 1 transmit byte, 2 command |
| wr_data | input | 16 | Write data |
| sd_i | input | 1 | Serial data input |
| sclk | output | 1 | Shift clock, idles high |
| sd_o | output | 1 | Serial data output |
| sd_oe | output | 1 | Serial data output enable |
| rx_byte | output | 8 | Last received byte |
| done | output | 1 | Transfer complete flag |
| err | output | 1 | Refused start flag |

## Verification
The two functions that can fall into the same cycle are the end of a transfer and a new start command. The bench schedules a receive start so that it is sampled on the exact system clock edge that produces the eighth rising shift-clock edge of a running transmit. In that same transfer it also rewrites the transmit byte and the divisor. The outcome is judged at the pins. The scoreboard must still see the original byte with the original period. done must stay set and err must stay clear. No further shift-clock edge may appear once the release delay is over, and any extra edge is reported as a transfer with nothing expected.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_LOW  = 2'd1,
      SQ_HIGH = 2'd2,
      SQ_TAIL = 2'd3
   } sq_state_t;

   localparam logic [1:0] RA_BAUD = 2'd0;
   localparam logic [1:0] RA_TXD  = 2'd1;
   localparam logic [1:0] RA_CTRL = 2'd2;

   localparam int CTRL_GO = 0;
   localparam int CTRL_TX = 1;
endpackage

// File: rtl/ssp_regs.sv
module ssp_regs
   import ssp_pkg::*;
#(
   parameter int BAUD_W     = 16,
   parameter int DATA_W     = 8,
   parameter int TX_MIN_DIV = 1,
   parameter int RX_MIN_DIV = 2,
   localparam int DIV_W     = BAUD_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [BAUD_W-1:0] wr_data,
   input  logic              busy,
   output logic [DIV_W-1:0]  div_n,
   output logic [DATA_W-1:0] tx_data,
   output logic              go_ok,
   output logic              go_tx,
   output logic              err
);
   logic [BAUD_W-1:0] baud_q;
   logic [DATA_W-1:0] txd_q;
   logic              err_q;
   logic              go_req;
   logic              legal;
   logic [DIV_W-1:0]  min_n;

   assign go_tx  = wr_data[CTRL_TX];
   assign go_req = wr_en && (wr_addr == RA_CTRL) && wr_data[CTRL_GO] && !busy;
   assign min_n  = go_tx ? DIV_W'(TX_MIN_DIV) : DIV_W'(RX_MIN_DIV);
   assign legal  = baud_q[BAUD_W-1] && (baud_q[DIV_W-1:0] >= min_n);
   assign go_ok  = go_req && legal;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         baud_q <= '0;
         txd_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         if (wr_en && wr_addr == RA_BAUD) baud_q <= wr_data;
         if (wr_en && wr_addr == RA_TXD)  txd_q  <= wr_data[DATA_W-1:0];
         if (go_req) err_q <= !legal;
      end
   end

   assign div_n   = baud_q[DIV_W-1:0];
   assign tx_data = txd_q;
   assign err     = err_q;
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq
   import ssp_pkg::*;
#(
   parameter int DIV_W     = 15,
   parameter int BITS      = 8,
   parameter int FLOAT_DLY = 5,
   localparam int BIT_W    = $clog2(BITS),
   localparam int TAIL_W   = $clog2(FLOAT_DLY + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             go_tx,
   input  logic [DIV_W-1:0] div_n,
   output logic             sclk,
   output logic             busy,
   output logic             done,
   output logic             rise_p,
   output logic             launch_p,
   output logic             last_p,
   output logic             float_p
);
   sq_state_t         st;
   logic [DIV_W-1:0]  cnt;
   logic [DIV_W-1:0]  n_q;
   logic [BIT_W-1:0]  bit_q;
   logic [TAIL_W-1:0] tail_q;
   logic              tx_q;
   logic              sclk_q;
   logic              done_q;
   logic              half_end;

   assign half_end = (cnt == n_q);
   assign rise_p   = (st == SQ_LOW) && half_end;
   assign last_p   = rise_p && (bit_q == BIT_W'(BITS - 1));
   assign launch_p = (st == SQ_HIGH) && (cnt == '0) && tx_q;
   assign float_p  = (st == SQ_TAIL) && (tail_q == TAIL_W'(FLOAT_DLY - 1));
   assign busy     = (st != SQ_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= SQ_IDLE;
         cnt    <= '0;
         n_q    <= '0;
         bit_q  <= '0;
         tail_q <= '0;
         tx_q   <= 1'b0;
         sclk_q <= 1'b1;
         done_q <= 1'b0;
      end else begin
         case (st)
            SQ_IDLE: if (go) begin
               st     <= SQ_LOW;
               sclk_q <= 1'b0;
               cnt    <= '0;
               bit_q  <= '0;
               n_q    <= div_n;
               tx_q   <= go_tx;
               done_q <= 1'b0;
            end
            SQ_LOW: if (half_end) begin
               sclk_q <= 1'b1;
               cnt    <= '0;
               if (last_p) begin
                  done_q <= 1'b1;
                  tail_q <= '0;
                  st     <= tx_q ? SQ_TAIL : SQ_IDLE;
               end else begin
                  st <= SQ_HIGH;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
            SQ_HIGH: if (half_end) begin
               sclk_q <= 1'b0;
               cnt    <= '0;
               bit_q  <= bit_q + 1'b1;
               st     <= SQ_LOW;
            end else begin
               cnt <= cnt + 1'b1;
            end
            SQ_TAIL: if (float_p) st <= SQ_IDLE;
                     else         tail_q <= tail_q + 1'b1;
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign sclk = sclk_q;
   assign done = done_q;

   // R2
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_IDLE || st == SQ_TAIL) |-> sclk_q);
endmodule

// File: rtl/ssp_shift.sv
module ssp_shift #(
   parameter int DATA_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_tx,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              launch_p,
   input  logic              rise_p,
   input  logic              last_p,
   input  logic              float_p,
   input  logic              sd_i,
   output logic              sd_o,
   output logic              sd_oe,
   output logic [DATA_W-1:0] rx_byte
);
   logic [DATA_W-1:0] tx_sr, rx_sr, rxb_q;
   logic [DATA_W-1:0] tx_shifted, rx_shifted;
   logic              head_load, head_next;
   logic              sdo_q, oe_q, mode_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign tx_shifted = {1'b0, tx_sr[DATA_W-1:1]};
         assign head_load  = tx_data[0];
         assign head_next  = tx_sr[1];
         assign rx_shifted = {sd_i, rx_sr[DATA_W-1:1]};
      end else begin : g_msb
         assign tx_shifted = {tx_sr[DATA_W-2:0], 1'b0};
         assign head_load  = tx_data[DATA_W-1];
         assign head_next  = tx_sr[DATA_W-2];
         assign rx_shifted = {rx_sr[DATA_W-2:0], sd_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr  <= '0;
         rx_sr  <= '0;
         rxb_q  <= '0;
         sdo_q  <= 1'b1;
         oe_q   <= 1'b0;
         mode_q <= 1'b0;
      end else if (load) begin
         tx_sr  <= tx_data;
         rx_sr  <= '0;
         sdo_q  <= head_load;
         oe_q   <= load_tx;
         mode_q <= load_tx;
      end else begin
         if (launch_p) begin
            tx_sr <= tx_shifted;
            sdo_q <= head_next;
         end
         if (rise_p && !mode_q) begin
            rx_sr <= rx_shifted;
            if (last_p) rxb_q <= rx_shifted;
         end
         if (float_p) oe_q <= 1'b0;
      end
   end

   assign sd_o    = sdo_q;
   assign sd_oe   = oe_q;
   assign rx_byte = rxb_q;

   // R10
   oe_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> mode_q);
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
   parameter int BAUD_W     = 16,
   parameter int DATA_W     = 8,
   parameter int TX_MIN_DIV = 1,
   parameter int RX_MIN_DIV = 2,
   parameter int FLOAT_DLY  = 5,
   parameter bit LSB_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [BAUD_W-1:0] wr_data,
   input  logic              sd_i,
   output logic              sclk,
   output logic              sd_o,
   output logic              sd_oe,
   output logic [DATA_W-1:0] rx_byte,
   output logic              done,
   output logic              err
);
   localparam int DIV_W = BAUD_W - 1;

   generate
      if (BAUD_W < 3) begin : g_bad_baud
         $error("BAUD_W must be at least 3");
      end
      if (DATA_W < 2 || DATA_W > BAUD_W) begin : g_bad_data
         $error("DATA_W must lie in 2..BAUD_W");
      end
      if (FLOAT_DLY < 1) begin : g_bad_float
         $error("FLOAT_DLY must be at least 1");
      end
      if (TX_MIN_DIV < 1 || RX_MIN_DIV < 1) begin : g_bad_min
         $error("minimum divisors must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0]  div_n;
   logic [DATA_W-1:0] tx_data;
   logic go_ok, go_tx, busy;
   logic rise_p, launch_p, last_p, float_p;

   ssp_regs #(
      .BAUD_W(BAUD_W), .DATA_W(DATA_W),
      .TX_MIN_DIV(TX_MIN_DIV), .RX_MIN_DIV(RX_MIN_DIV)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .div_n(div_n), .tx_data(tx_data),
      .go_ok(go_ok), .go_tx(go_tx), .err(err)
   );

   ssp_seq #(
      .DIV_W(DIV_W), .BITS(DATA_W), .FLOAT_DLY(FLOAT_DLY)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go_ok), .go_tx(go_tx), .div_n(div_n),
      .sclk(sclk), .busy(busy), .done(done), .rise_p(rise_p),
      .launch_p(launch_p), .last_p(last_p), .float_p(float_p)
   );

   ssp_shift #(
      .DATA_W(DATA_W), .LSB_FIRST(LSB_FIRST)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .load(go_ok), .load_tx(go_tx),
      .tx_data(tx_data), .launch_p(launch_p), .rise_p(rise_p),
      .last_p(last_p), .float_p(float_p), .sd_i(sd_i),
      .sd_o(sd_o), .sd_oe(sd_oe), .rx_byte(rx_byte)
   );

   // R3
   data_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sd_oe) && sd_oe && !$stable(sd_o)) |-> (sclk && $past(sclk)));

   // R9
   done_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $rose(sclk));

   // R10
   float_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sd_oe) |-> sclk);

   // R8
   reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> (sclk && !sd_oe));
endmodule

// File: tb/sync_shift_port_test.sv
`timescale 1ns/100ps
module sync_shift_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic        sd_i = 1'b0;
   logic        sclk, sd_o, sd_oe, done, err;
   logic [7:0]  rx_byte;

   always #2.5 clk = ~clk;

   sync_shift_port uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .sd_i(sd_i), .sclk(sclk), .sd_o(sd_o),
      .sd_oe(sd_oe), .rx_byte(rx_byte), .done(done), .err(err)
   );

   typedef struct { bit tx; int n; logic [7:0] data; } item_t;
   item_t q[$];
   int nchk = 0, nfail = 0, completed = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_done(input int target);
      while (completed < target) @(negedge clk);
   endtask

   task automatic xfer(input bit tx, input int n, input logic [7:0] d);
      item_t it;
      int target;
      it.tx = tx; it.n = n; it.data = d;
      wr(2'd0, 16'h8000 | 16'(n));
      if (tx) wr(2'd1, {8'h00, d});
      q.push_back(it);
      target = completed + 1;
      wr(2'd2, {14'd0, tx, 1'b1});
      chk(err == 1'b0, "R8", "err after accepted start", err, 0);
      chk(done == 1'b0, "R8", "done after accepted start", done, 0);
      wait_done(target);
   endtask

   task automatic quiet(input string req, input int cycles);
      bit ok = 1;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (!sclk || sd_oe) ok = 0;
      end
      chk(ok, req, "shift clock idle high with line released", ok, 1);
   endtask

   // scoreboard monitor
   initial begin
      item_t cur;
      bit prev = 1, active = 0, tail = 0;
      int cyc = 0, rises = 0, fall_c = 0, rise_c = 0;
      forever begin
         @(negedge clk);
         cyc++;
         if (rst_n) begin
            if (!active) begin
               if (prev && !sclk) begin
                  if (q.size() == 0) begin
                     chk(0, "R11", "unexpected shift clock activity", 1, 0);
                  end else begin
                     cur = q.pop_front();
                     active = 1; tail = 0; rises = 0; fall_c = cyc;
                     if (!cur.tx) sd_i = cur.data[0];
                  end
               end
            end else if (tail) begin
               if (!sd_oe) begin
                  chk(cyc - rise_c == 5, "R10", "release delay", cyc - rise_c, 5);
                  active = 0; completed++;
               end
            end else begin
               if (prev && !sclk) begin
                  chk(cyc - rise_c == cur.n + 1, "R2", "high half", cyc - rise_c, cur.n + 1);
                  fall_c = cyc;
                  if (!cur.tx) sd_i = cur.data[rises];
               end else if (!prev && sclk) begin
                  chk(cyc - fall_c == cur.n + 1, "R2", "low half", cyc - fall_c, cur.n + 1);
                  if (rises > 0)
                     chk(cyc - rise_c == 2 * (cur.n + 1), cur.tx ? "R5" : "R6",
                         "period", cyc - rise_c, 2 * (cur.n + 1));
                  if (cur.tx) begin
                     chk(sd_oe == 1'b1, "R3", "output enable during send", sd_oe, 1);
                     chk(sd_o == cur.data[rises], "R3", "sent bit", sd_o, cur.data[rises]);
                  end else begin
                     chk(sd_oe == 1'b0, "R10", "enable in receive", sd_oe, 0);
                  end
                  rises++;
                  rise_c = cyc;
                  if (rises < 8) begin
                     chk(done == 1'b0, "R9", "done early", done, 0);
                  end else begin
                     chk(done == 1'b1, "R9", "done on eighth rise", done, 1);
                     if (cur.tx) tail = 1;
                     else begin
                        chk(rx_byte == cur.data, "R4", "received byte", rx_byte, cur.data);
                        active = 0; completed++;
                     end
                  end
               end
            end
         end
         prev = sclk;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      int target;
      item_t it;
      repeat (3) @(negedge clk);
      // R1 reset values
      chk(sclk == 1'b1, "R1", "sclk", sclk, 1);
      chk(sd_oe == 1'b0, "R1", "sd_oe", sd_oe, 0);
      chk(done == 1'b0 && err == 1'b0, "R1", "done/err", {done, err}, 0);
      chk(rx_byte == 8'h00, "R1", "rx_byte", rx_byte, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      xfer(1'b1, 1, 8'hA5);   // R5 minimum transmit divisor
      xfer(1'b1, 3, 8'h3C);   // R3
      xfer(1'b0, 2, 8'h96);   // R6 minimum receive divisor
      xfer(1'b0, 4, 8'h4B);   // R4

      // R5 transmit with N=0 refused
      wr(2'd0, 16'h8000);
      wr(2'd2, 16'h0003);
      chk(err == 1'b1, "R5", "err on N=0 send", err, 1);
      chk(done == 1'b1, "R8", "done kept on refusal", done, 1);
      quiet("R8", 20);
      // R6 receive with N=1 refused
      wr(2'd0, 16'h8001);
      wr(2'd2, 16'h0001);
      chk(err == 1'b1, "R6", "err on N=1 receive", err, 1);
      quiet("R6", 20);
      // R7 internal select bit clear
      wr(2'd0, 16'h0005);
      wr(2'd2, 16'h0003);
      chk(err == 1'b1, "R7", "err with bit15 clear", err, 1);
      quiet("R7", 20);

      xfer(1'b1, 5, 8'h81);   // R8 err cleared by this start

      // R11 collision: start sampled on the eighth rise, mid-transfer rewrites
      wr(2'd0, 16'h8002);
      wr(2'd1, 16'h00C3);
      it.tx = 1; it.n = 2; it.data = 8'hC3;
      q.push_back(it);
      target = completed + 1;
      @(negedge clk); wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0003;
      @(negedge clk); wr_en = 1'b0;
      repeat (4) @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'h00FF;
      @(negedge clk); wr_addr = 2'd0; wr_data = 16'h8007;
      @(negedge clk); wr_en = 1'b0;
      repeat (38) @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0001;
      @(negedge clk); wr_en = 1'b0;
      chk(done == 1'b1, "R11", "done at collision", done, 1);
      chk(err == 1'b0, "R11", "err at collision", err, 0);
      wait_done(target);
      quiet("R11", 30);
      chk(done == 1'b1, "R11", "done after ignored start", done, 1);
      chk(q.size() == 0, "R11", "scoreboard drained", q.size(), 0);

      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule